// File: doc/BRIEF.md
# RS485 Driver-Enable Timing Sequencer

This block drives the enable line of an external half-duplex line transceiver around a burst of serial characters. When a transmit request arrives while the line is idle, the enable output turns on at once. The block then holds the transmitter back for a programmed lead time and releases it with a one-clock go pulse. The enable stays on while characters follow one another. After the last stop bit it stays on for a programmed trail time and then turns off.

Both guard times are given as 5-bit fields and are scaled by a 10-bit prescale value taken from the baud divisor. When the prescale is non-zero a field F yields 1 + F·P clock cycles. When the prescale is zero the same field yields 1 + F cycles. The active level of the enable line is selectable. With the mode bit cleared, the enable line rests at its inactive level and requests pass straight through to the go output.

Top module: `rs485_de_seq`

## Requirements
- R1: While reset is asserted and after its release, `de_out` sits at the inactive level (the inverse of `de_pol`) and `tx_go` is 0.
- R2: With `de_mode` at 0, `de_out` stays at the inactive level, and `tx_go` equals the value `tx_req` had one clock earlier.
- R3: The active level of `de_out` equals `de_pol`: 1 gives active-high and 0 gives active-low.
- R4: With `de_mode` at 1, a `tx_req` sampled while idle makes `de_out` active from the next clock. With `prescale` non-zero, `tx_go` rises exactly 1 + `lead_cfg`·`prescale` clocks after `de_out` becomes active.
- R5: With `prescale` equal to 0, the lead interval of R4 is 1 + `lead_cfg` clocks, and the trail interval of R7 is 1 + `trail_cfg` clocks.
- R6: `tx_go` is a single pulse for each lead interval. Further `tx_req` pulses and `stop_done` pulses during the lead interval are ignored.
- R7: A `stop_done` sampled during a transmission, with no `tx_req` in the same clock, keeps `de_out` active for exactly 1 + `trail_cfg`·`prescale` clocks (or the count of R5 when `prescale` is 0) and then returns it to inactive.
- R8: A `tx_req` sampled during the trail interval, including its final clock, keeps `de_out` active, abandons the trail and raises `tx_go` on the next clock without a new lead interval.
- R9: While transmitting, a `tx_req` raises `tx_go` on the next clock. When it coincides with `stop_done`, no trail interval starts.
- R10: Clearing `de_mode` during any phase returns `de_out` to inactive from the next clock and cancels any pending go pulse.
- R11: The largest settings (`lead_cfg` or `trail_cfg` = 31, `prescale` = 1023) give 31714-clock intervals without counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| de_mode | input | 1 | Enables the driver-enable sequencing |
| de_pol | input | 1 | Active level of `de_out` |
| lead_cfg | input | 5 | Lead (assertion) guard field |
| trail_cfg | input | 5 | Trail (de-assertion) guard field |
| prescale | input | 10 | Baud-divisor scale value P |
| tx_req | input | 1 | Transmit request from the character source |
| stop_done | input | 1 | Pulse at the end of the last stop bit |
| de_out | output | 1 | Transceiver driver-enable line |
| tx_go | output | 1 | One-clock permission for the shifter to start |

## Verification
The two functions that can fall in the same clock are the expiry of the trail countdown and a fresh transmit request. A request timed for the last trail clock must win: the enable line stays active and a go pulse follows with no lead delay. The bench provokes this by counting clocks from a `stop_done` pulse and raising `tx_req` exactly on the final trail clock. It also raises `tx_req` together with `stop_done` during a transmission. A behavioural reference model, compared on every clock, judges both the enable level and the go pulse. Directed interval measurements confirm the counts independently of the model.

// File: rtl/rs485_de_pkg.sv
package rs485_de_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_LEAD   = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_TRAIL  = 2'd3
   } de_phase_t;

   function automatic logic phase_drives(input de_phase_t ph);
      return ph != PH_IDLE;
   endfunction

endpackage

// File: rtl/rs485_guard_calc.sv
module rs485_guard_calc #(
   parameter int FIELD_W  = 5,
   parameter int PRESC_W  = 10,
   parameter bit USE_MULT = 1'b1,
   localparam int CNT_W   = FIELD_W + PRESC_W
) (
   input  logic [FIELD_W-1:0] field,
   input  logic [PRESC_W-1:0] presc,
   output logic [CNT_W-1:0]   len
);

   logic [CNT_W-1:0] scaled;

   generate
      if (FIELD_W < 1 || PRESC_W < 1) begin : g_bad_width
         $error("rs485_guard_calc: field and prescale widths must be positive");
      end

      if (USE_MULT) begin : g_mult
         assign scaled = CNT_W'(field) * CNT_W'(presc);
      end else begin : g_shift_add
         logic [CNT_W-1:0] part [FIELD_W+1];
         assign part[0] = '0;
         for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
            assign part[i+1] = part[i] +
                               (field[i] ? (CNT_W'(presc) << i) : '0);
         end
         assign scaled = part[FIELD_W];
      end
   endgenerate

   always_comb begin
      if (presc == '0) len = CNT_W'(field) + CNT_W'(1);
      else             len = scaled + CNT_W'(1);
   end

   // p_len_nonzero_r5: every guard length is at least one clock
   always_comb begin
      if (!$isunknown(len)) begin
         p_len_nonzero_r5: assert (len != '0)
            else $error("guard length computed as zero");
      end
   end

endmodule

// File: rtl/rs485_guard_timer.sv
module rs485_guard_timer #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             expire
);

   logic [CNT_W-1:0] cnt;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("rs485_guard_timer: counter width too small");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt <= '0;
      else if (load)                 cnt <= load_val;
      else if (run && cnt > CNT_W'(1)) cnt <= cnt - CNT_W'(1);
   end

   assign expire = run && (cnt == CNT_W'(1));

   // R11: a running countdown never sits at zero (no wrap)
   p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt != '0));

   // R11: while running and not yet expired, the count falls by one
   p_dec_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !expire) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/rs485_de_fsm.sv
module rs485_de_fsm
   import rs485_de_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      de_mode,
   input  logic      tx_req,
   input  logic      stop_done,
   input  logic      expire,
   output logic      load_lead,
   output logic      load_trail,
   output logic      run,
   output logic      drive,
   output logic      tx_go
);

   de_phase_t ph, ph_nx;
   logic      go_nx;

   always_comb begin
      ph_nx      = ph;
      go_nx      = 1'b0;
      load_lead  = 1'b0;
      load_trail = 1'b0;
      if (!de_mode) begin
         ph_nx = PH_IDLE;
         go_nx = tx_req;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (tx_req) begin
                  ph_nx     = PH_LEAD;
                  load_lead = 1'b1;
               end
            end
            PH_LEAD: begin
               if (expire) begin
                  ph_nx = PH_ACTIVE;
                  go_nx = 1'b1;
               end
            end
            PH_ACTIVE: begin
               if (tx_req) begin
                  go_nx = 1'b1;
               end else if (stop_done) begin
                  ph_nx      = PH_TRAIL;
                  load_trail = 1'b1;
               end
            end
            PH_TRAIL: begin
               if (tx_req) begin
                  ph_nx = PH_ACTIVE;
                  go_nx = 1'b1;
               end else if (expire) begin
                  ph_nx = PH_IDLE;
               end
            end
            default: ph_nx = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         tx_go <= 1'b0;
      end else begin
         ph    <= ph_nx;
         tx_go <= go_nx;
      end
   end

   assign run   = (ph == PH_LEAD) || (ph == PH_TRAIL);
   assign drive = phase_drives(ph);

   // R2 / R10: mode bit low forces idle and passes requests straight through
   p_mode_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !de_mode |=> (ph == PH_IDLE && tx_go == $past(tx_req)));

   // R4: the lead phase is entered only from idle
   p_lead_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_LEAD && $past(ph) != PH_LEAD) |-> ($past(ph) == PH_IDLE));

   // R6: a go pulse has a request or an expiring lead behind it
   p_go_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |-> ($past(tx_req) || $past(ph) == PH_LEAD));

   // R8: a request in the trail phase resumes transmission at once
   p_trail_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_TRAIL && tx_req && de_mode) |=> (ph == PH_ACTIVE && tx_go));

   // R9: request together with stop_done keeps the burst going
   p_no_trail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_ACTIVE && tx_req && stop_done && de_mode) |=> (ph == PH_ACTIVE));

endmodule

// File: rtl/rs485_de_seq.sv
module rs485_de_seq #(
   parameter int FIELD_W  = 5,
   parameter int PRESC_W  = 10,
   parameter bit USE_MULT = 1'b1,
   localparam int CNT_W   = FIELD_W + PRESC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               de_mode,
   input  logic               de_pol,
   input  logic [FIELD_W-1:0] lead_cfg,
   input  logic [FIELD_W-1:0] trail_cfg,
   input  logic [PRESC_W-1:0] prescale,
   input  logic               tx_req,
   input  logic               stop_done,
   output logic               de_out,
   output logic               tx_go
);

   logic [CNT_W-1:0] lead_len, trail_len, load_val;
   logic             load_lead, load_trail, run, expire, drive;

   rs485_guard_calc #(.FIELD_W(FIELD_W), .PRESC_W(PRESC_W), .USE_MULT(USE_MULT))
   u_lead_calc (
      .field (lead_cfg),
      .presc (prescale),
      .len   (lead_len)
   );

   rs485_guard_calc #(.FIELD_W(FIELD_W), .PRESC_W(PRESC_W), .USE_MULT(USE_MULT))
   u_trail_calc (
      .field (trail_cfg),
      .presc (prescale),
      .len   (trail_len)
   );

   assign load_val = load_lead ? lead_len : trail_len;

   rs485_guard_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_lead | load_trail),
      .load_val (load_val),
      .run      (run),
      .expire   (expire)
   );

   rs485_de_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .de_mode    (de_mode),
      .tx_req     (tx_req),
      .stop_done  (stop_done),
      .expire     (expire),
      .load_lead  (load_lead),
      .load_trail (load_trail),
      .run        (run),
      .drive      (drive),
      .tx_go      (tx_go)
   );

   assign de_out = drive ? de_pol : ~de_pol;

   // R3: with the mode bit low the line rests at the inactive level
   p_inactive_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!de_mode) |-> (de_out == ~de_pol));

   // R4: a go pulse is only issued while the line is driven (mode on)
   p_go_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_go && $past(de_mode) && de_mode) |-> (de_out == de_pol));

endmodule

// File: tb/rs485_de_seq_test.sv
module rs485_de_seq_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       de_mode, de_pol;
   logic [4:0] lead_cfg, trail_cfg;
   logic [9:0] prescale;
   logic       tx_req, stop_done;
   logic       de_out, tx_go;

   int total = 0;
   int bad   = 0;
   bit cmp_on = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   rs485_de_seq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .de_mode   (de_mode),
      .de_pol    (de_pol),
      .lead_cfg  (lead_cfg),
      .trail_cfg (trail_cfg),
      .prescale  (prescale),
      .tx_req    (tx_req),
      .stop_done (stop_done),
      .de_out    (de_out),
      .tx_go     (tx_go)
   );

   // ---------------- behavioural reference ----------------
   int m_ph   = 0;   // 0 off, 1 waiting lead, 2 sending, 3 waiting trail
   int m_left = 0;
   bit m_go   = 0;

   function automatic int guard(input int f, input int p);
      return (p == 0) ? (1 + f) : (1 + f * p);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_go = 0; m_left = 0;
      end else if (!de_mode) begin
         m_ph = 0; m_go = tx_req;
      end else begin
         case (m_ph)
            0: begin
               m_go = 0;
               if (tx_req) begin m_ph = 1; m_left = guard(lead_cfg, prescale); end
            end
            1: begin
               if (m_left == 1) begin m_ph = 2; m_go = 1; end
               else begin m_left--; m_go = 0; end
            end
            2: begin
               m_go = tx_req;
               if (!tx_req && stop_done) begin
                  m_ph = 3; m_left = guard(trail_cfg, prescale);
               end
            end
            default: begin
               if (tx_req) begin m_ph = 2; m_go = 1; end
               else if (m_left == 1) begin m_ph = 0; m_go = 0; end
               else begin m_left--; m_go = 0; end
            end
         endcase
      end
   end

   task automatic expect_eq(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         expect_eq({cur_req, " model de_out"}, de_out,
                   (m_ph != 0) ? de_pol : !de_pol);
         expect_eq({cur_req, " model tx_go"}, tx_go, m_go);
      end
   end

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   // ---------------- directed helpers ----------------
   function automatic logic act_lvl();
      return de_pol;
   endfunction

   task automatic idle_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure_lead(input int exp_n, input string tag);
      int n;
      @(negedge clk); #1 tx_req = 1'b1;
      @(negedge clk);
      expect_eq({tag, " de active after request"}, de_out, act_lvl());
      #1 tx_req = 1'b0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tx_go && n < 40000);
      expect_eq({tag, " lead clocks"}, n, exp_n);
   endtask

   task automatic measure_trail(input int exp_n, input string tag);
      int n;
      @(negedge clk); #1 stop_done = 1'b1;
      @(negedge clk); #1 stop_done = 1'b0;
      n = 0;
      while (de_out == act_lvl() && n < 40000) begin
         n++;
         @(negedge clk);
      end
      expect_eq({tag, " trail clocks"}, n, exp_n);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      int go_cnt;
      rst_n = 1'b0; de_mode = 1'b0; de_pol = 1'b1;
      lead_cfg = '0; trail_cfg = '0; prescale = '0;
      tx_req = 1'b0; stop_done = 1'b0;

      // R1: reset state, both polarities
      idle_cycles(3);
      expect_eq("R1 reset de_out pol1", de_out, 0);
      expect_eq("R1 reset tx_go", tx_go, 0);
      #1 de_pol = 1'b0;
      @(negedge clk);
      expect_eq("R1 reset de_out pol0", de_out, 1);
      #1 de_pol = 1'b1; rst_n = 1'b1; de_mode = 1'b1;
      @(negedge clk);
      expect_eq("R1 after release de_out", de_out, 0);
      expect_eq("R1 after release tx_go", tx_go, 0);
      cmp_on = 1'b1;

      // R4: scaled lead, R7: scaled trail
      cur_req = "R4";
      lead_cfg = 5'd3; trail_cfg = 5'd2; prescale = 10'd4;
      measure_lead(13, "R4");
      idle_cycles(2);
      cur_req = "R7";
      measure_trail(9, "R7");
      idle_cycles(2);

      // R5: zero prescale collapses to plain counts
      cur_req = "R5";
      #1 lead_cfg = 5'd5; trail_cfg = 5'd0; prescale = 10'd0;
      measure_lead(6, "R5");
      measure_trail(1, "R5");
      idle_cycles(2);

      // R3: active-low polarity
      cur_req = "R3";
      #1 de_pol = 1'b0; lead_cfg = 5'd1; trail_cfg = 5'd1; prescale = 10'd2;
      @(negedge clk);
      expect_eq("R3 idle level active-low", de_out, 1);
      measure_lead(3, "R3");
      expect_eq("R3 active level active-low", de_out, 0);
      #1 prescale = 10'd0;
      measure_trail(2, "R3");
      expect_eq("R3 back to idle level", de_out, 1);
      #1 de_pol = 1'b1;
      idle_cycles(2);

      // R6: extra requests and stop_done during lead are ignored
      cur_req = "R6";
      #1 lead_cfg = 5'd4; trail_cfg = 5'd0; prescale = 10'd3;
      @(negedge clk); #1 tx_req = 1'b1;
      @(negedge clk); #1 tx_req = 1'b0;
      idle_cycles(2); #1 tx_req = 1'b1; stop_done = 1'b1;
      @(negedge clk); #1 tx_req = 1'b0; stop_done = 1'b0;
      go_cnt = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (tx_go) go_cnt++;
      end
      expect_eq("R6 go pulses in one lead", go_cnt, 1);
      expect_eq("R6 de still active", de_out, 1);

      // R9: request in active phase, and together with stop_done
      cur_req = "R9";
      #1 tx_req = 1'b1;
      @(negedge clk);
      expect_eq("R9 go after request in active", tx_go, 1);
      #1 stop_done = 1'b1;
      @(negedge clk);
      expect_eq("R9 go with coinciding stop", tx_go, 1);
      #1 tx_req = 1'b0; stop_done = 1'b0;
      idle_cycles(5);
      expect_eq("R9 no trail started", de_out, 1);
      measure_trail(1, "R9");

      // R8: request in mid trail, then on the final trail clock
      cur_req = "R8";
      #1 lead_cfg = 5'd0; trail_cfg = 5'd10; prescale = 10'd0;
      measure_lead(1, "R8");
      @(negedge clk); #1 stop_done = 1'b1;
      @(negedge clk); #1 stop_done = 1'b0;
      idle_cycles(3); #1 tx_req = 1'b1;
      @(negedge clk);
      expect_eq("R8 go mid trail", tx_go, 1);
      expect_eq("R8 de kept mid trail", de_out, 1);
      #1 tx_req = 1'b0;
      idle_cycles(15);
      expect_eq("R8 trail abandoned", de_out, 1);
      #1 trail_cfg = 5'd2;
      @(negedge clk); #1 stop_done = 1'b1;
      @(negedge clk); #1 stop_done = 1'b0;
      @(negedge clk);
      @(negedge clk); #1 tx_req = 1'b1;
      @(negedge clk);
      expect_eq("R8 go on final trail clock", tx_go, 1);
      expect_eq("R8 de kept on final trail clock", de_out, 1);
      #1 tx_req = 1'b0;
      measure_trail(3, "R8");
      idle_cycles(2);

      // R10: mode bit cleared mid lead
      cur_req = "R10";
      #1 lead_cfg = 5'd20; prescale = 10'd2;
      @(negedge clk); #1 tx_req = 1'b1;
      @(negedge clk); #1 tx_req = 1'b0;
      idle_cycles(5); #1 de_mode = 1'b0;
      @(negedge clk);
      expect_eq("R10 de inactive after mode clear", de_out, 0);
      go_cnt = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (tx_go) go_cnt++;
      end
      expect_eq("R10 pending go cancelled", go_cnt, 0);

      // R2: pass-through when mode is off
      cur_req = "R2";
      #1 tx_req = 1'b1;
      @(negedge clk);
      expect_eq("R2 go follows request", tx_go, 1);
      expect_eq("R2 de stays inactive", de_out, 0);
      #1 tx_req = 1'b0;
      @(negedge clk);
      expect_eq("R2 go drops with request", tx_go, 0);
      #1 de_mode = 1'b1;
      idle_cycles(2);

      // R11: largest intervals
      cur_req = "R11";
      #1 lead_cfg = 5'd31; trail_cfg = 5'd31; prescale = 10'd1023;
      measure_lead(31714, "R11");
      measure_trail(31714, "R11");
      idle_cycles(3);

      cmp_on = 1'b0;
      finish_run();
   end

endmodule